// File: doc/BRIEF.md
# Three-Wire Transceiver Control Slave

This block is the register side of an infrared transceiver's three-wire control bus. A controller drives a serial clock and a write-data line, which doubles as the transmit-data input. The block answers on a read-data line, which doubles as the receive-data output. The block runs on a fast system clock that oversamples the serial clock through synchronizers. It frames the bus into bytes, decodes two- and three-byte write and read commands, and keeps the mode, I/O-enable and power-level registers.

Because the LED input and the write line share a wire, the block raises an LED-disable flag on the first serial clock rising edge of a transaction. It drops the flag on the last clock of that transaction. While it drives a read response, it also gates off the receive detector. A read does not end after a fixed count of bits. It ends when the write line shows a closing pattern.

Top module: `trx_ctl_slave`

## Requirements
- R1: After reset, the block is in sleep (norm_mode_o=0), with the receive output disabled (rx_en_o=0), the transmitter disabled (tx_en_o=0), the low-rate mode selected (mir_mode_o=0) and full power (pwr_lvl_o=2'b11).
- R2: On the first serial clock rising edge after idle, led_dis_o rises within four system clocks. It stays high until the last clock of the transaction and then returns low.
- R3: The first rising edge after the pending edge is a start clock. Every byte, in both the command and the response, is preceded by exactly one start clock, with no gaps between bytes. Bits are sampled on rising edges, least significant first. Command byte 0 holds C in bit 0 (1=write, 0=read), the index in bits [4:1] and the address in bits [7:5].
- R4: Writing index 0 sets norm_mode_o from data bit 0, rx_en_o from bit 1 and tx_en_o from bit 2. The other data bits are dropped, and reads of index 0 return the three bits in their positions.
- R5: Writing index 1 sets mir_mode_o from data bit 0. Reads return 0x00 for the low-rate mode and 0x01 for the high-rate mode.
- R6: Writing index 2 sets pwr_lvl_o from data bits [7:6] (00=10%, 01=25%, 10=50%, 11=100%). Reads return the code in bits [7:6] with the lower bits zero.
- R7: Index 15 is extended. The second byte is an 8-bit extended index and the third byte is data. Extended index 0x00 reads 0x01, 0x01 reads 0x41, any other value reads 0x00, and writes to extended indices have no effect.
- R8: A command whose address is not 000 changes no register, and srd_oe_o stays low throughout its response.
- R9: In a read, the slave updates srd_o on each response-bit rising edge, least significant bit first. rx_gate_o is high from the end of the command phase until the transaction ends.
- R10: A read ends on the rising edge at which the last three response-phase samples of the write line are high, low, low, in that order. With no such pattern the transaction stays open.
- R11: Indices 3 to 14 read as 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bus clock |
| swd_i | input | 1 | Serial write data (shared with transmit data) |
| srd_o | output | 1 | Serial read data |
| srd_oe_o | output | 1 | High while srd_o carries response bits |
| led_dis_o | output | 1 | LED disable while a transaction is open |
| rx_gate_o | output | 1 | Receive detector gated off during the response |
| norm_mode_o | output | 1 | 1 = normal, 0 = sleep |
| rx_en_o | output | 1 | Receive output enable |
| tx_en_o | output | 1 | Transmitter enable |
| mir_mode_o | output | 1 | 1 = high-rate mode, 0 = low-rate mode |
| pwr_lvl_o | output | 2 | Optical power code |

## Verification
The properties assume that the serial clock and write line reach the block as clean levels, with every serial high and low phase lasting several system clocks. They also assume that the write line changes only while the serial clock is low. The bench drives both lines from the falling side of the system clock. It holds each serial phase for eight system clocks and changes the write line only right after a serial falling edge. Under those conditions each serial edge gives exactly one internal edge pulse. Registers then change only on the closing clock of a write.

// File: rtl/trx_ctl_pkg.sv
package trx_ctl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PEND  = 2'd1,
    PH_START = 2'd2,
    PH_BITS  = 2'd3
  } phase_e;

  localparam logic [3:0] IDX_CTRL = 4'h0;
  localparam logic [3:0] IDX_RATE = 4'h1;
  localparam logic [3:0] IDX_PWR  = 4'h2;
  localparam logic [3:0] IDX_EXT  = 4'hF;
  localparam logic [2:0] END_PAT  = 3'b100;
endpackage

// File: rtl/trx_ctl_sync.sv
module trx_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic swd_i,
  output logic sclk_rise,
  output logic swd_s
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] wd_q;
  logic              ck_prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ck_q[0] <= 1'b0;
            wd_q[0] <= 1'b0;
          end else begin
            ck_q[0] <= sclk_i;
            wd_q[0] <= swd_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ck_q[g] <= 1'b0;
            wd_q[g] <= 1'b0;
          end else begin
            ck_q[g] <= ck_q[g-1];
            wd_q[g] <= wd_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev_q <= 1'b0;
    else        ck_prev_q <= ck_q[STAGES-1];
  end

  assign sclk_rise = ck_q[STAGES-1] & ~ck_prev_q;
  assign swd_s     = wd_q[STAGES-1];
endmodule

// File: rtl/trx_ctl_regs.sv
module trx_ctl_regs #(
  parameter logic [7:0] MFR_ID  = 8'h01,
  parameter logic [7:0] PROD_ID = 8'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [3:0] idx,
  input  logic [7:0] eidx,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       norm_mode,
  output logic       rx_en,
  output logic       tx_en,
  output logic       mir_mode,
  output logic [1:0] pwr_lvl
);
  import trx_ctl_pkg::*;

  logic [2:0] ctrl_q, ctrl_d;
  logic       rate_q, rate_d;
  logic [1:0] pwr_q,  pwr_d;
  logic       ctrl_en, rate_en, pwr_en;

  always_comb begin
    ctrl_en = wr_stb && (idx == IDX_CTRL);
    rate_en = wr_stb && (idx == IDX_RATE);
    pwr_en  = wr_stb && (idx == IDX_PWR);
    ctrl_d  = wr_data[2:0];
    rate_d  = wr_data[0];
    pwr_d   = wr_data[7:6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 3'b000;
      rate_q <= 1'b0;
      pwr_q  <= 2'b11;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (rate_en) rate_q <= rate_d;
      if (pwr_en)  pwr_q  <= pwr_d;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    unique case (idx)
      IDX_CTRL: rd_data = {5'b0, ctrl_q};
      IDX_RATE: rd_data = {7'b0, rate_q};
      IDX_PWR:  rd_data = {pwr_q, 6'b0};
      IDX_EXT: begin
        if (eidx == 8'h00)      rd_data = MFR_ID;
        else if (eidx == 8'h01) rd_data = PROD_ID;
        else                    rd_data = 8'h00;
      end
      default:  rd_data = 8'h00;
    endcase
  end

  assign norm_mode = ctrl_q[0];
  assign rx_en     = ctrl_q[1];
  assign tx_en     = ctrl_q[2];
  assign mir_mode  = rate_q;
  assign pwr_lvl   = pwr_q;
endmodule

// File: rtl/trx_ctl_frame.sv
module trx_ctl_frame #(
  parameter logic [2:0] DEV_ADDR = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  input  logic       swd,
  input  logic [7:0] rd_data,
  output logic       wr_stb,
  output logic [3:0] idx,
  output logic [7:0] eidx,
  output logic [7:0] wr_data,
  output logic       led_dis,
  output logic       rx_gate,
  output logic       srd,
  output logic       srd_oe
);
  import trx_ctl_pkg::*;

  phase_e     ph_q, ph_d;
  logic [1:0] byte_q, byte_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] cmd_q, cmd_d;
  logic [7:0] eidx_q, eidx_d;
  logic       resp_q, resp_d;
  logic [2:0] hist_q, hist_d;
  logic       srd_q, srd_d;
  logic       oe_q, oe_d;
  logic [7:0] byte_val;
  logic       addr_ok;
  logic       is_ext;
  logic       is_wr;

  always_comb begin
    ph_d     = ph_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    cmd_d    = cmd_q;
    eidx_d   = eidx_q;
    resp_d   = resp_q;
    hist_d   = hist_q;
    srd_d    = srd_q;
    oe_d     = oe_q;
    wr_stb   = 1'b0;
    wr_data  = 8'h00;
    byte_val = {swd, sh_q[7:1]};
    addr_ok  = (cmd_q[7:5] == DEV_ADDR);
    is_ext   = (cmd_q[4:1] == IDX_EXT);
    is_wr    = cmd_q[0];
    if (rise) begin
      unique case (ph_q)
        PH_IDLE: ph_d = PH_PEND;
        PH_PEND: begin
          ph_d   = PH_BITS;
          byte_d = 2'd0;
          bit_d  = 3'd0;
        end
        PH_START: begin
          ph_d  = PH_BITS;
          bit_d = 3'd0;
          if (resp_q) hist_d = {hist_q[1:0], swd};
        end
        PH_BITS: begin
          if (resp_q) begin
            hist_d = {hist_q[1:0], swd};
            srd_d  = rd_data[bit_q];
            oe_d   = addr_ok;
            if (bit_q != 3'd7) bit_d = bit_q + 3'd1;
            if (hist_d == END_PAT) begin
              ph_d   = PH_IDLE;
              resp_d = 1'b0;
              oe_d   = 1'b0;
            end
          end else begin
            sh_d = byte_val;
            if (bit_q != 3'd7) begin
              bit_d = bit_q + 3'd1;
            end else begin
              ph_d = PH_START;
              unique case (byte_q)
                2'd0: begin
                  cmd_d  = byte_val;
                  byte_d = 2'd1;
                  if (!byte_val[0] && (byte_val[4:1] != IDX_EXT)) begin
                    resp_d = 1'b1;
                    hist_d = 3'b000;
                  end
                end
                2'd1: begin
                  byte_d = 2'd2;
                  if (is_ext) begin
                    eidx_d = byte_val;
                    if (!is_wr) begin
                      resp_d = 1'b1;
                      hist_d = 3'b000;
                    end
                  end else begin
                    ph_d    = PH_IDLE;
                    wr_stb  = addr_ok;
                    wr_data = byte_val;
                  end
                end
                default: begin
                  ph_d    = PH_IDLE;
                  wr_stb  = addr_ok && is_wr;
                  wr_data = byte_val;
                end
              endcase
            end
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      byte_q <= 2'd0;
      bit_q  <= 3'd0;
      sh_q   <= 8'h00;
      cmd_q  <= 8'h00;
      eidx_q <= 8'h00;
      resp_q <= 1'b0;
      hist_q <= 3'b000;
      srd_q  <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      byte_q <= byte_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      cmd_q  <= cmd_d;
      eidx_q <= eidx_d;
      resp_q <= resp_d;
      hist_q <= hist_d;
      srd_q  <= srd_d;
      oe_q   <= oe_d;
    end
  end

  assign idx     = cmd_q[4:1];
  assign eidx    = eidx_q;
  assign led_dis = (ph_q != PH_IDLE);
  assign rx_gate = resp_q;
  assign srd     = srd_q;
  assign srd_oe  = oe_q;
endmodule

// File: rtl/trx_ctl_slave.sv
module trx_ctl_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] DEV_ADDR    = 3'b000,
  parameter logic [7:0] MFR_ID      = 8'h01,
  parameter logic [7:0] PROD_ID     = 8'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       swd_i,
  output logic       srd_o,
  output logic       srd_oe_o,
  output logic       led_dis_o,
  output logic       rx_gate_o,
  output logic       norm_mode_o,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       mir_mode_o,
  output logic [1:0] pwr_lvl_o
);
  logic       rst_a_q, rst_b_q;
  logic       sclk_rise, swd_s;
  logic       wr_stb;
  logic [3:0] idx;
  logic [7:0] eidx, wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end

  trx_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_b_q), .sclk_i(sclk_i), .swd_i(swd_i),
    .sclk_rise(sclk_rise), .swd_s(swd_s)
  );

  trx_ctl_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
    .clk(clk), .rst_n(rst_b_q), .rise(sclk_rise), .swd(swd_s),
    .rd_data(rd_data), .wr_stb(wr_stb), .idx(idx), .eidx(eidx),
    .wr_data(wr_data), .led_dis(led_dis_o), .rx_gate(rx_gate_o),
    .srd(srd_o), .srd_oe(srd_oe_o)
  );

  trx_ctl_regs #(.MFR_ID(MFR_ID), .PROD_ID(PROD_ID)) u_regs (
    .clk(clk), .rst_n(rst_b_q), .wr_stb(wr_stb), .idx(idx), .eidx(eidx),
    .wr_data(wr_data), .rd_data(rd_data), .norm_mode(norm_mode_o),
    .rx_en(rx_en_o), .tx_en(tx_en_o), .mir_mode(mir_mode_o),
    .pwr_lvl(pwr_lvl_o)
  );
endmodule

// File: rtl/trx_ctl_chk.sv
module trx_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk_rise,
  input logic       led_dis,
  input logic       rx_gate,
  input logic       srd_oe,
  input logic       norm_mode,
  input logic       rx_en,
  input logic       tx_en,
  input logic       mir_mode,
  input logic [1:0] pwr_lvl
);
  // R1: reset values seen on the first cycle after reset release
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwr_lvl == 2'b11 && !norm_mode && !rx_en && !tx_en && !mir_mode));

  // R2: a serial rising edge seen while idle opens the transaction
  p_led_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !led_dis) |=> led_dis);

  // R2: detector gating only inside an open transaction
  p_gate_in_txn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gate |-> led_dis);

  // R9: response drive only while the detector is gated
  p_oe_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srd_oe |-> rx_gate);

  // R4: registers move only on the cycle a transaction closes
  p_regs_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!led_dis && !$past(led_dis)) |->
      $stable({norm_mode, rx_en, tx_en, mir_mode, pwr_lvl}));
endmodule

bind trx_ctl_slave trx_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .led_dis(led_dis_o),
  .rx_gate(rx_gate_o), .srd_oe(srd_oe_o), .norm_mode(norm_mode_o),
  .rx_en(rx_en_o), .tx_en(tx_en_o), .mir_mode(mir_mode_o), .pwr_lvl(pwr_lvl_o)
);

// File: tb/sim_trx_ctl_slave.sv
module sim_trx_ctl_slave;
  localparam int HALF = 8;
  localparam int NV   = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic swd = 1'b0;
  logic srd, srd_oe, led_dis, rx_gate, norm, rxe, txe, mir;
  logic [1:0] pwr;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trx_ctl_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .swd_i(swd), .srd_o(srd),
    .srd_oe_o(srd_oe), .led_dis_o(led_dis), .rx_gate_o(rx_gate),
    .norm_mode_o(norm), .rx_en_o(rxe), .tx_en_o(txe), .mir_mode_o(mir),
    .pwr_lvl_o(pwr)
  );

  // {wr, addr[2:0], idx[3:0], eidx[7:0], data_or_expected[7:0]}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 3'd0, 4'h0, 8'h00, 8'h00},  // R1 ctrl reset
    {1'b0, 3'd0, 4'h1, 8'h00, 8'h00},  // R1 rate reset
    {1'b0, 3'd0, 4'h2, 8'h00, 8'hC0},  // R1 power reset
    {1'b0, 3'd0, 4'hF, 8'h00, 8'h01},  // R7 maker code
    {1'b0, 3'd0, 4'hF, 8'h01, 8'h41},  // R7 product code
    {1'b0, 3'd0, 4'hF, 8'h07, 8'h00},  // R7 unknown ext
    {1'b1, 3'd0, 4'h0, 8'h00, 8'hFF},  // R4 write ctrl
    {1'b0, 3'd0, 4'h0, 8'h00, 8'h07},  // R4 read ctrl
    {1'b1, 3'd0, 4'h1, 8'h00, 8'h01},  // R5 write rate
    {1'b0, 3'd0, 4'h1, 8'h00, 8'h01},  // R5 read rate
    {1'b1, 3'd0, 4'h2, 8'h00, 8'h7F},  // R6 write power
    {1'b0, 3'd0, 4'h2, 8'h00, 8'h40},  // R6 read power
    {1'b1, 3'd3, 4'h0, 8'h00, 8'h00},  // R8 foreign address
    {1'b0, 3'd0, 4'h0, 8'h00, 8'h07},  // R8 unchanged
    {1'b1, 3'd0, 4'h5, 8'h00, 8'hFF},  // R11 write unknown
    {1'b0, 3'd0, 4'h5, 8'h00, 8'h00},  // R11 read unknown
    {1'b1, 3'd0, 4'hF, 8'h01, 8'h00},  // R7 write ext ignored
    {1'b0, 3'd0, 4'hF, 8'h01, 8'h41}   // R7 still product
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic d);
    @(negedge clk);
    swd = d;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic rd_pulse(input logic d, output logic s, output logic oe, output logic g);
    @(negedge clk);
    swd = d;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    s = srd; oe = srd_oe; g = rx_gate;
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    pulse(1'b0);
    for (int i = 0; i < 8; i++) pulse(b[i]);
  endtask

  task automatic idle_gap();
    @(negedge clk);
    swd = 1'b0;
    repeat (6 * HALF) @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [3:0] ix,
                          input logic [7:0] ex, input logic [7:0] d);
    pulse(1'b0);
    send_byte({a, ix, 1'b1});
    if (ix == 4'hF) send_byte(ex);
    send_byte(d);
    idle_gap();
  endtask

  task automatic do_read(input logic [2:0] a, input logic [3:0] ix, input logic [7:0] ex,
                         output logic [7:0] q, output logic oe_any, output logic g_all);
    logic s, oe, g;
    pulse(1'b0);
    send_byte({a, ix, 1'b0});
    if (ix == 4'hF) send_byte(ex);
    oe_any = 1'b0; g_all = 1'b1;
    rd_pulse(1'b0, s, oe, g);
    g_all &= g;
    for (int i = 0; i < 8; i++) begin
      rd_pulse(i == 5, s, oe, g);
      q[i] = s;
      oe_any |= oe;
      if (i < 7) g_all &= g;
    end
    idle_gap();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic oe_any, g_all, s, oe, g;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state at the ports
    check(!norm && !rxe && !txe && !mir && pwr == 2'b11 && !led_dis,
          "R1 reset ports", {norm, rxe, txe, mir, pwr}, 6'b000011);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][23]) begin
        do_write(VEC[v][22:20], VEC[v][19:16], VEC[v][15:8], VEC[v][7:0]);
      end else begin
        do_read(VEC[v][22:20], VEC[v][19:16], VEC[v][15:8], q, oe_any, g_all);
        check(q == VEC[v][7:0], $sformatf("R3/R9 read vector %0d", v), q, VEC[v][7:0]);
      end
    end

    // R4 port view after table writes (ctrl 0x07)
    check(norm && rxe && txe, "R4 ctrl ports", {norm, rxe, txe}, 3'b111);
    // R5 port view
    check(mir, "R5 rate port", mir, 1);

    // R4 partial pattern
    do_write(3'd0, 4'h0, 8'h00, 8'hFA);
    check(!norm && rxe && !txe, "R4 ctrl 0xFA", {norm, rxe, txe}, 3'b010);

    // R6 all power codes
    for (int p = 0; p < 4; p++) begin
      do_write(3'd0, 4'h2, 8'h00, {p[1:0], 6'b101010});
      check(pwr == p[1:0], "R6 power code", pwr, p);
    end

    // R2 LED disable on pending edge and release after write
    check(!led_dis, "R2 idle before", led_dis, 0);
    pulse(1'b0);
    check(led_dis, "R2 led after pending edge", led_dis, 1);
    send_byte({3'd0, 4'h1, 1'b1});
    check(led_dis && !rx_gate, "R2 led held during command", {led_dis, rx_gate}, 2'b10);
    send_byte(8'h00);
    idle_gap();
    check(!led_dis && !mir, "R2 led released, R5 rate low", {led_dis, mir}, 2'b00);

    // R8 foreign address read: no drive, still closes
    do_read(3'd5, 4'h0, 8'h00, q, oe_any, g_all);
    check(!oe_any && !led_dis, "R8 no drive on foreign read", {oe_any, led_dis}, 0);

    // R9 detector gate throughout response, drive on local read
    do_read(3'd0, 4'h2, 8'h00, q, oe_any, g_all);
    check(g_all && oe_any && q == 8'hC0, "R9 gate and drive", {g_all, oe_any, q}, {2'b11, 8'hC0});
    check(!rx_gate, "R9 gate released", rx_gate, 0);

    // R10 no closing pattern keeps the read open
    pulse(1'b0);
    send_byte({3'd0, 4'h0, 1'b0});
    for (int i = 0; i < 12; i++) rd_pulse(1'b0, s, oe, g);
    check(led_dis && rx_gate, "R10 open without pattern", {led_dis, rx_gate}, 2'b11);
    rd_pulse(1'b1, s, oe, g);
    rd_pulse(1'b0, s, oe, g);
    check(led_dis, "R10 still open mid pattern", led_dis, 1);
    rd_pulse(1'b0, s, oe, g);
    idle_gap();
    check(!led_dis && !rx_gate, "R10 closed by pattern", {led_dis, rx_gate}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule